// File: doc/BRIEF.md
# Strobe-Driven Slave FIFO Read Port

This block is the read side of a bank of four slave FIFOs. An external master controls it with three asynchronous active-low strobes: chip select, output enable and read. A 2-bit address picks the FIFO whose data and flags are used. The strobes are brought into the local clock domain by a two-flop synchronizer, and the block then detects their edges.

Output enable controls only whether the data bus is driven. On its own it shows the word held from the last read. The falling edge of the read strobe, taken while chip select is low, loads the word at the FIFO's read pointer into the output register. The read pointer advances when the strobe is released. Strobe pulses that are too short are flagged and have no effect on the pointer. A read of an empty FIFO leaves both the pointer and the held word unchanged.

A synchronous push port fills the FIFOs so that the block can be tested. The bus is brought out as a data value plus a drive enable, which the pad ring turns into a tri-state driver.

Top module: `sfrd_port`

## Requirements
- R1: After reset every FIFO is empty (`empty_o`=1, `full_o`=0), the held word `data_o` is 0, the bus is not driven (`data_oe_o`=0), and `underflow_o` and `pulse_err_o` are 0.
- R2: `data_oe_o` is 1 exactly while the synchronized output enable is low, two clock edges after `oe_ni` changes. Otherwise the bus is released.
- R3: Output enable asserted with no read strobe drives the previously held word and does not change any pointer.
- R4: A valid read loads the word at the read pointer of the addressed FIFO. The pointer advances by one after the strobe is released, so successive reads return words in write order. When the last word has been read, `empty_o` is 1.
- R5: A read strobe that goes active while `cs_ni` is high loads nothing and advances nothing.
- R6: `addr_i` selects the FIFO whose word is loaded and whose `empty_o`/`full_o` are shown.
- R7: A read strobe active for fewer than `MIN_ACT` (default 3) synchronized cycles sets the sticky `pulse_err_o` and does not advance the pointer.
- R8: A read strobe that goes active after fewer than `MIN_INACT` (default 2) inactive cycles sets `pulse_err_o` and is ignored: no load and no advance.
- R9: A read of an empty FIFO sets the sticky `underflow_o`, keeps the held word, and leaves the pointer unchanged.
- R10: A FIFO holds `DEPTH` (16) words. `full_o` is 1 after 16 pushes, and a push into a full FIFO is dropped. `empty_o` and `full_o` are never both 1.
- R11: With `oe_ni` and `rd_ni` tied together, the newly read word appears on the driven bus and the pointer advances on release.
- R12: The new word appears on `data_o` at the third clock edge after the read strobe falls, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| rd_ni | input | 1 | Read strobe, active low, asynchronous |
| addr_i | input | 2 | FIFO select for read data and flags |
| wr_en_i | input | 1 | Synchronous push enable |
| wr_sel_i | input | 2 | FIFO select for the push |
| wr_data_i | input | 16 | Push data |
| data_o | output | 16 | Held read word (bus value) |
| data_oe_o | output | 1 | Bus drive enable; 0 means high-impedance |
| empty_o | output | 1 | Addressed FIFO is empty |
| full_o | output | 1 | Addressed FIFO is full |
| underflow_o | output | 1 | Sticky: an empty FIFO was read |
| pulse_err_o | output | 1 | Sticky: read strobe pulse-width violation |

## Verification
The cases that are hardest to reach from the ports are those that must leave no visible trace: a rejected pulse and a read that fails on an empty FIFO. Neither one changes the bus. The bench drives the strobes on falling clock edges so that their active and inactive widths are exact cycle counts. After each rejected pulse it issues a well-formed read and checks that the word returned is the one the pointer held before, which shows the pointer did not move. The timing of the word load is checked by sampling the bus one edge before and at the edge where the load is due.

// File: rtl/sfrd_pkg.sv
package sfrd_pkg;
  typedef struct packed {
    logic cs;
    logic oe;
    logic rd;
  } strobe_t;
endpackage

// File: rtl/sfrd_sync.sv
module sfrd_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/sfrd_bank.sv
module sfrd_bank #(
  parameter int N_FIFO = 4,
  parameter int DEPTH  = 16,
  parameter int DW     = 16,
  localparam int AW    = $clog2(N_FIFO),
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          adv_i,
  input  logic [AW-1:0] adv_sel_i,
  input  logic [AW-1:0] rd_sel_i,
  output logic [DW-1:0] rd_word_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [DW-1:0] word_v [N_FIFO];
  logic [N_FIFO-1:0] empty_v, full_v;

  for (genvar g = 0; g < N_FIFO; g++) begin : g_fifo
    logic [DW-1:0] mem [DEPTH];
    logic [PW:0]   wptr_q, rptr_q;
    logic          push;

    assign empty_v[g] = (wptr_q == rptr_q);
    assign full_v[g]  = (wptr_q[PW-1:0] == rptr_q[PW-1:0]) && (wptr_q[PW] != rptr_q[PW]);
    assign push       = wr_en_i && (wr_sel_i == AW'(g)) && !full_v[g];
    assign word_v[g]  = mem[rptr_q[PW-1:0]];

    always_ff @(posedge clk_i) begin
      if (push) mem[wptr_q[PW-1:0]] <= wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wptr_q <= '0;
        rptr_q <= '0;
      end else begin
        if (push) wptr_q <= wptr_q + 1'b1;
        if (adv_i && (adv_sel_i == AW'(g)) && !empty_v[g]) rptr_q <= rptr_q + 1'b1;
      end
    end
  end

  assign rd_word_o = word_v[rd_sel_i];
  assign empty_o   = empty_v[rd_sel_i];
  assign full_o    = full_v[rd_sel_i];
endmodule

// File: rtl/sfrd_ctrl.sv
module sfrd_ctrl #(
  parameter int N_FIFO    = 4,
  parameter int MIN_ACT   = 3,
  parameter int MIN_INACT = 2,
  localparam int AW       = $clog2(N_FIFO),
  localparam int ACW      = $clog2(MIN_ACT + 1),
  localparam int ICW      = $clog2(MIN_INACT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          rd_i,
  input  logic [AW-1:0] sel_i,
  input  logic          empty_i,
  output logic          cap_o,
  output logic          adv_o,
  output logic [AW-1:0] adv_sel_o,
  output logic          underflow_o,
  output logic          pulse_err_o
);
  logic           rd_q, live_q, uf_q, err_q;
  logic [ACW-1:0] act_cnt_q;
  logic [ICW-1:0] ina_cnt_q;
  logic [AW-1:0]  sel_q;
  logic           start, stop, gap_ok, act_ok;

  assign start  = rd_i && !rd_q;
  assign stop   = !rd_i && rd_q;
  assign gap_ok = (ina_cnt_q >= ICW'(MIN_INACT));
  assign act_ok = (act_cnt_q >= ACW'(MIN_ACT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q      <= 1'b0;
      live_q    <= 1'b0;
      uf_q      <= 1'b0;
      err_q     <= 1'b0;
      act_cnt_q <= '0;
      ina_cnt_q <= ICW'(MIN_INACT);
      sel_q     <= '0;
    end else begin
      rd_q <= rd_i;
      if (start) begin
        act_cnt_q <= ACW'(1);
        sel_q     <= sel_i;
        if (!gap_ok) begin
          err_q  <= 1'b1;
          live_q <= 1'b0;
        end else if (!cs_i) begin
          live_q <= 1'b0;
        end else if (empty_i) begin
          uf_q   <= 1'b1;
          live_q <= 1'b0;
        end else begin
          live_q <= 1'b1;
        end
      end else if (rd_i) begin
        if (!act_ok) act_cnt_q <= act_cnt_q + 1'b1;
        if (!cs_i) live_q <= 1'b0;  // select dropped mid-strobe: abort
      end
      if (stop) begin
        ina_cnt_q <= ICW'(1);
        live_q    <= 1'b0;
        if (!act_ok) err_q <= 1'b1;
      end else if (!rd_i && !gap_ok) begin
        ina_cnt_q <= ina_cnt_q + 1'b1;
      end
    end
  end

  assign cap_o       = start && gap_ok && cs_i && !empty_i;
  assign adv_o       = stop && live_q && act_ok;
  assign adv_sel_o   = sel_q;
  assign underflow_o = uf_q;
  assign pulse_err_o = err_q;
endmodule

// File: rtl/sfrd_port.sv
module sfrd_port #(
  parameter int N_FIFO    = 4,
  parameter int DEPTH     = 16,
  parameter int DW        = 16,
  parameter int MIN_ACT   = 3,
  parameter int MIN_INACT = 2,
  localparam int AW       = $clog2(N_FIFO)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          oe_ni,
  input  logic          rd_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          underflow_o,
  output logic          pulse_err_o
);
  import sfrd_pkg::*;

  strobe_t       strb_s;
  logic [2:0]    strb_raw, strb_q;
  logic          cap, adv;
  logic [AW-1:0] adv_sel;
  logic [DW-1:0] rd_word, word_q;

  assign strb_raw = {~cs_ni, ~oe_ni, ~rd_ni};

  sfrd_sync #(.W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (strb_raw),
    .q_o   (strb_q)
  );
  assign strb_s = strobe_t'(strb_q);

  sfrd_ctrl #(
    .N_FIFO(N_FIFO), .MIN_ACT(MIN_ACT), .MIN_INACT(MIN_INACT)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_i       (strb_s.cs),
    .rd_i       (strb_s.rd),
    .sel_i      (addr_i),
    .empty_i    (empty_o),
    .cap_o      (cap),
    .adv_o      (adv),
    .adv_sel_o  (adv_sel),
    .underflow_o(underflow_o),
    .pulse_err_o(pulse_err_o)
  );

  sfrd_bank #(.N_FIFO(N_FIFO), .DEPTH(DEPTH), .DW(DW)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .adv_i    (adv),
    .adv_sel_i(adv_sel),
    .rd_sel_i (addr_i),
    .rd_word_o(rd_word),
    .empty_o  (empty_o),
    .full_o   (full_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  word_q <= '0;
    else if (cap) word_q <= rd_word;
  end

  assign data_o    = word_q;
  assign data_oe_o = strb_s.oe;
endmodule

// File: rtl/sfrd_port_chk.sv
module sfrd_port_chk #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          oe_ni,
  input logic          cap_i,
  input logic [DW-1:0] data_o,
  input logic          data_oe_o,
  input logic          empty_o,
  input logic          full_o,
  input logic          underflow_o,
  input logic          pulse_err_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R2
  bus_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (data_oe_o == !$past(oe_ni, 2)));

  // R4
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd1 && data_o != $past(data_o)) |-> $past(cap_i));

  // R9
  uf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underflow_o) |=> underflow_o);

  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_err_o |=> pulse_err_o);

  // R10
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o));
endmodule

bind sfrd_port sfrd_port_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .oe_ni      (oe_ni),
  .cap_i      (cap),
  .data_o     (data_o),
  .data_oe_o  (data_oe_o),
  .empty_o    (empty_o),
  .full_o     (full_o),
  .underflow_o(underflow_o),
  .pulse_err_o(pulse_err_o)
);

// File: tb/sim_sfrd_port.sv
`timescale 1ns/1ps
module sim_sfrd_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, oe_n, rd_n;
  logic [1:0]  addr, wr_sel;
  logic        wr_en;
  logic [15:0] wr_data, data;
  logic        data_oe, empty, full, uf, perr;
  int          n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  sfrd_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .oe_ni(oe_n), .rd_ni(rd_n),
    .addr_i(addr), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .data_o(data), .data_oe_o(data_oe), .empty_o(empty), .full_o(full),
    .underflow_o(uf), .pulse_err_o(perr)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cs_n = 1'b1; oe_n = 1'b1; rd_n = 1'b1;
    addr = 2'd0; wr_sel = 2'd0; wr_en = 1'b0; wr_data = '0;
    cyc(2);
    rst_n = 1'b1;
    cyc(4);
  endtask

  task automatic push(input logic [1:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  // one strobe: act cycles low, then gap cycles high
  task automatic strobe(input int act, input int gap);
    rd_n = 1'b0;
    cyc(act);
    rd_n = 1'b1;
    cyc(gap);
  endtask

  task automatic rd_word(input logic [1:0] sel, output logic [15:0] w);
    addr = sel; cs_n = 1'b0;
    cyc(1);
    strobe(3, 4);
    w = data;
  endtask

  task automatic t_reset();
    do_reset();
    for (int i = 0; i < 4; i++) begin
      addr = 2'(i); cyc(1);
      chk("R1 empty", 16'(empty), 16'd1);
      chk("R1 full", 16'(full), 16'd0);
    end
    chk("R1 data", data, 16'h0);
    chk("R1 oe", 16'(data_oe), 16'd0);
    chk("R1 flags", {14'd0, uf, perr}, 16'd0);
  endtask

  task automatic t_oe_only();
    logic [15:0] w;
    do_reset();
    push(2'd0, 16'h1111); push(2'd0, 16'h2222);
    oe_n = 1'b0;
    cyc(1);
    chk("R2 oe after one edge", 16'(data_oe), 16'd0);
    cyc(1);
    chk("R2 oe after two edges", 16'(data_oe), 16'd1);
    cyc(3);
    chk("R3 oe alone shows held word", data, 16'h0);
    oe_n = 1'b1;
    cyc(3);
    chk("R2 released", 16'(data_oe), 16'd0);
    rd_word(2'd0, w);
    chk("R3 pointer not moved by oe", w, 16'h1111);
  endtask

  task automatic t_read();
    logic [15:0] w;
    do_reset();
    push(2'd0, 16'hA001); push(2'd0, 16'hA002);
    cs_n = 1'b0; oe_n = 1'b0;
    cyc(3);
    rd_n = 1'b0;
    cyc(2);
    chk("R12 not before third edge", data, 16'h0);
    cyc(1);
    chk("R12 word at third edge", data, 16'hA001);
    cyc(1);
    rd_n = 1'b1;
    cyc(4);
    chk("R4 bus driven with word", 16'(data_oe), 16'd1);
    chk("R4 not empty after one", 16'(empty), 16'd0);
    rd_word(2'd0, w);
    chk("R4 second word", w, 16'hA002);
    chk("R4 empty after last", 16'(empty), 16'd1);
  endtask

  task automatic t_addr();
    logic [15:0] w;
    do_reset();
    push(2'd1, 16'hB111); push(2'd2, 16'hC222);
    addr = 2'd3; cyc(1);
    chk("R6 fifo3 empty", 16'(empty), 16'd1);
    addr = 2'd1; cyc(1);
    chk("R6 fifo1 not empty", 16'(empty), 16'd0);
    rd_word(2'd2, w);
    chk("R6 fifo2 word", w, 16'hC222);
    addr = 2'd1; cyc(1);
    chk("R6 fifo1 untouched", 16'(empty), 16'd0);
  endtask

  task automatic t_nocs();
    logic [15:0] w;
    do_reset();
    push(2'd3, 16'hD333);
    addr = 2'd3; cs_n = 1'b1;
    cyc(1);
    strobe(3, 4);
    chk("R5 no load without select", data, 16'h0);
    chk("R5 no advance", 16'(empty), 16'd0);
    rd_word(2'd3, w);
    chk("R5 word still first", w, 16'hD333);
  endtask

  task automatic t_short();
    logic [15:0] w;
    do_reset();
    push(2'd0, 16'h3333); push(2'd0, 16'h4444);
    addr = 2'd0; cs_n = 1'b0;
    cyc(1);
    strobe(2, 4);
    chk("R7 short pulse flagged", 16'(perr), 16'd1);
    rd_word(2'd0, w);
    chk("R7 pointer not advanced", w, 16'h3333);
    rd_word(2'd0, w);
    chk("R7 then next word", w, 16'h4444);
  endtask

  task automatic t_gap();
    logic [15:0] w;
    do_reset();
    push(2'd0, 16'h5555); push(2'd0, 16'h6666); push(2'd0, 16'h7777);
    addr = 2'd0; cs_n = 1'b0;
    cyc(1);
    strobe(3, 1);
    strobe(3, 4);
    chk("R8 short gap flagged", 16'(perr), 16'd1);
    chk("R8 second read ignored", data, 16'h5555);
    rd_word(2'd0, w);
    chk("R8 pointer moved once", w, 16'h6666);
  endtask

  task automatic t_underflow();
    logic [15:0] w;
    do_reset();
    push(2'd2, 16'hE000);
    rd_word(2'd2, w);
    rd_word(2'd2, w);
    chk("R9 underflow set", 16'(uf), 16'd1);
    chk("R9 held word kept", w, 16'hE000);
    push(2'd2, 16'hE001);
    rd_word(2'd2, w);
    chk("R9 pointer unchanged", w, 16'hE001);
    chk("R9 flag sticky", 16'(uf), 16'd1);
  endtask

  task automatic t_full();
    logic [15:0] w;
    do_reset();
    addr = 2'd1;
    for (int i = 0; i < 16; i++) push(2'd1, 16'h0100 + 16'(i));
    chk("R10 full after depth", 16'(full), 16'd1);
    push(2'd1, 16'hDEAD);
    for (int i = 0; i < 16; i++) begin
      rd_word(2'd1, w);
      chk("R10 order", w, 16'h0100 + 16'(i));
    end
    chk("R10 extra push dropped", 16'(empty), 16'd1);
    chk("R10 no underflow", 16'(uf), 16'd0);
  endtask

  task automatic t_tied();
    do_reset();
    push(2'd0, 16'hF0F0); push(2'd0, 16'hF1F1);
    addr = 2'd0; cs_n = 1'b0;
    cyc(1);
    rd_n = 1'b0; oe_n = 1'b0;
    cyc(3);
    chk("R11 tied bus driven", 16'(data_oe), 16'd1);
    chk("R11 tied word", data, 16'hF0F0);
    rd_n = 1'b1; oe_n = 1'b1;
    cyc(4);
    chk("R11 tied released", 16'(data_oe), 16'd0);
    rd_n = 1'b0; oe_n = 1'b0;
    cyc(3);
    chk("R11 tied second word", data, 16'hF1F1);
    rd_n = 1'b1; oe_n = 1'b1;
    cyc(4);
    chk("R11 tied empty", 16'(empty), 16'd1);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; oe_n = 1'b1; rd_n = 1'b1;
    addr = '0; wr_sel = '0; wr_en = 1'b0; wr_data = '0;
    t_reset();
    t_oe_only();
    t_read();
    t_addr();
    t_nocs();
    t_short();
    t_gap();
    t_underflow();
    t_full();
    t_tied();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule